// File: doc/BRIEF.md
# LIN Transceiver Mode Controller

This block is the digital supervisor of a LIN physical-layer transceiver. It holds the power mode of the transceiver: unpowered, pre-normal (fail-safe), normal or sleep. It moves between these modes on a qualified supply-good level, the enable pin and two wake requests. From the mode it derives the inhibit output that switches an external regulator, the communication enable, the bus pull-up enable, and the request that makes the bus driver pull LIN dominant.

All inputs are already-qualified logic levels, synchronous to `clk_i`. Every delay is a count of clock ticks. A guard on the transmit input cuts the driver when TXD stays dominant too long. A variant parameter selects one of three behaviour sets. The sets differ in the length of this time-out and in whether a TXD that is already low when normal mode is entered may drive the bus.

Top module: `lin_mode_ctrl`

## Requirements
- R1: While `rst_ni` is low, `mode_o` is 0 and `inh_o`, `comm_en_o`, `pullup_en_o`, `lin_dom_o` and `txd_tmo_o` are all 0.
- R2: `mode_o` encodes 0 = unpowered, 1 = pre-normal, 2 = normal, 3 = sleep. When `vs_ok_i` is sampled low at a clock edge, the controller is in mode 0 after that edge, whatever the other inputs are. After that same edge the power-up count restarts.
- R3: When the controller is in mode 0 and `vs_ok_i` is sampled high, it moves to mode 1 at that edge. `inh_o` rises once `vs_ok_i` has been sampled high on PWRUP_TICKS consecutive edges.
- R4: In mode 1, normal mode (2) is entered at the edge that samples `en_i` high for the (NORM_TICKS+1)-th consecutive time. If `en_i` goes low earlier, the count restarts.
- R5: In mode 2, sleep (3) is entered at the edge that samples `en_i` low for the (SLEEP_TICKS+1)-th consecutive time. If `en_i` goes high earlier, the count restarts.
- R6: In mode 3, a high `bus_wake_i` or `local_wake_i` at an edge moves the controller to mode 1. In any other mode both wake inputs have no effect.
- R7: Once the power-up delay has elapsed, `inh_o` is 1 in modes 1 and 2 and 0 in mode 3. `comm_en_o` and `pullup_en_o` are 1 only in mode 2.
- R8: `lin_dom_o` is 1 only in mode 2 while `txd_i` is low, subject to R9 and R10.
- R9: After `txd_i` has been sampled low in mode 2 on the variant's number of edges, `lin_dom_o` falls and `txd_tmo_o` rises. The number is DOM_TICKS_A for VARIANT 0, DOM_TICKS_B for VARIANT 1 and DOM_TICKS_C for VARIANT 2. Both are released after the first edge that samples `txd_i` high.
- R10: With VARIANT 0, a `txd_i` that is already low when mode 2 is entered drives the bus dominant at once. With VARIANT 1 or 2 the bus stays recessive until an edge in mode 2 has sampled `txd_i` high.
- R11: Any VARIANT other than 1 or 2 behaves exactly like VARIANT 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock; one cycle is one delay tick |
| rst_ni | input | 1 | Asynchronous active-low reset |
| vs_ok_i | input | 1 | Supply above the undervoltage level |
| en_i | input | 1 | Enable pin level |
| txd_i | input | 1 | Transmit data, low = dominant |
| bus_wake_i | input | 1 | Qualified bus wake event |
| local_wake_i | input | 1 | Qualified local wake event |
| mode_o | output | 2 | Mode code: 0 unpowered, 1 pre-normal, 2 normal, 3 sleep |
| inh_o | output | 1 | Inhibit switch on |
| comm_en_o | output | 1 | Receiver and communication enabled |
| pullup_en_o | output | 1 | Bus pull-up enabled |
| lin_dom_o | output | 1 | Bus driver pulls LIN dominant |
| txd_tmo_o | output | 1 | Dominant time-out reached |

## Verification
The bench builds four copies that share the same inputs. They use VARIANT 0, 1, 2 and 5, so the three time-out lengths, the two entry behaviours and the fallback of an unknown variant can be compared edge by edge. The delays are shrunk to PWRUP_TICKS 12, NORM_TICKS 3 and SLEEP_TICKS 5. The dominant time-outs are 20, 35 and 27 ticks, so every timer boundary, and a timer restart, can be reached within a few dozen cycles. A random phase of several thousand cycles compares the VARIANT 0 copy against a cycle model in the bench. That phase covers supply drops in every mode, and wake pulses that arrive in the wrong mode.

// File: rtl/lin_mode_pkg.sv
package lin_mode_pkg;
  typedef enum logic [1:0] {
    MODE_OFF   = 2'd0,
    MODE_PRE   = 2'd1,
    MODE_NORM  = 2'd2,
    MODE_SLEEP = 2'd3
  } lin_mode_e;

  // unknown variants fall back to variant 0
  function automatic int unsigned dom_ticks_sel(input int variant,
                                                input int unsigned a,
                                                input int unsigned b,
                                                input int unsigned c);
    if (variant == 1) return b;
    if (variant == 2) return c;
    return a;
  endfunction
endpackage

// File: rtl/lin_tick_timer.sv
module lin_tick_timer #(
  parameter int unsigned TICKS = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  output logic done_o
);
  localparam int unsigned CW = $clog2(TICKS + 1);
  localparam logic [CW-1:0] LIMIT = CW'(TICKS);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)             cnt_q <= '0;
    else if (!run_i)         cnt_q <= '0;
    else if (cnt_q != LIMIT) cnt_q <= cnt_q + 1'b1;
  end

  assign done_o = (cnt_q == LIMIT);

  assert_cnt_bound_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= LIMIT);
  assert_cnt_clear_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run_i |=> cnt_q == '0);
endmodule

// File: rtl/lin_mode_fsm.sv
module lin_mode_fsm
  import lin_mode_pkg::*;
(
  input  logic      clk_i,
  input  logic      rst_ni,
  input  logic      vs_ok_i,
  input  logic      en_i,
  input  logic      bus_wake_i,
  input  logic      local_wake_i,
  input  logic      en_done_i,
  input  logic      sleep_done_i,
  output lin_mode_e mode_o
);
  lin_mode_e mode_q, mode_d;

  always_comb begin
    mode_d = mode_q;
    if (!vs_ok_i) mode_d = MODE_OFF;
    else begin
      unique case (mode_q)
        MODE_OFF:   mode_d = MODE_PRE;
        MODE_PRE:   if (en_i && en_done_i)      mode_d = MODE_NORM;
        MODE_NORM:  if (!en_i && sleep_done_i)  mode_d = MODE_SLEEP;
        MODE_SLEEP: if (bus_wake_i || local_wake_i) mode_d = MODE_PRE;
        default:    mode_d = MODE_OFF;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) mode_q <= MODE_OFF;
    else         mode_q <= mode_d;
  end

  assign mode_o = mode_q;

  assert_vs_low_off_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !vs_ok_i |=> mode_q == MODE_OFF);
  assert_power_up_pre_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_q == MODE_OFF && vs_ok_i) |=> mode_q == MODE_PRE);
  assert_norm_waits_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_q == MODE_PRE && !en_done_i) |=> mode_q != MODE_NORM);
  assert_sleep_waits_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_q == MODE_NORM && en_i) |=> mode_q != MODE_SLEEP);
  assert_wake_pre_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_q == MODE_SLEEP && vs_ok_i && (bus_wake_i || local_wake_i)) |=> mode_q == MODE_PRE);
endmodule

// File: rtl/lin_txd_guard.sv
module lin_txd_guard
  import lin_mode_pkg::*;
#(
  parameter int          VARIANT   = 0,
  parameter int unsigned DOM_TICKS = 40
) (
  input  logic      clk_i,
  input  logic      rst_ni,
  input  logic      vs_ok_i,
  input  lin_mode_e mode_i,
  input  logic      txd_i,
  output logic      dom_o,
  output logic      tmo_o
);
  logic in_norm, armed;

  assign in_norm = (mode_i == MODE_NORM);

  lin_tick_timer #(.TICKS(DOM_TICKS)) u_dom_timer (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .run_i  (vs_ok_i && in_norm && !txd_i),
    .done_o (tmo_o)
  );

  generate
    if (VARIANT == 1 || VARIANT == 2) begin : g_arm_on_high
      logic armed_q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)       armed_q <= 1'b0;
        else if (!in_norm) armed_q <= 1'b0;
        else if (txd_i)    armed_q <= 1'b1;
      end
      assign armed = armed_q;

      assert_disarm_outside_norm_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !in_norm |=> !armed_q);
    end else begin : g_arm_always
      assign armed = 1'b1;
    end
  endgenerate

  assign dom_o = in_norm && !txd_i && armed && !tmo_o;

  assert_tmo_holds_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tmo_o && !txd_i && in_norm && vs_ok_i) |=> tmo_o);
  assert_tmo_release_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    txd_i |=> !tmo_o);
endmodule

// File: rtl/lin_mode_ctrl.sv
module lin_mode_ctrl
  import lin_mode_pkg::*;
#(
  parameter int          VARIANT     = 0,
  parameter int unsigned PWRUP_TICKS = 100,
  parameter int unsigned NORM_TICKS  = 10,
  parameter int unsigned SLEEP_TICKS = 10,
  parameter int unsigned DOM_TICKS_A = 9000,
  parameter int unsigned DOM_TICKS_B = 55000,
  parameter int unsigned DOM_TICKS_C = 10000
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       vs_ok_i,
  input  logic       en_i,
  input  logic       txd_i,
  input  logic       bus_wake_i,
  input  logic       local_wake_i,
  output logic [1:0] mode_o,
  output logic       inh_o,
  output logic       comm_en_o,
  output logic       pullup_en_o,
  output logic       lin_dom_o,
  output logic       txd_tmo_o
);
  localparam int unsigned DOM_TICKS = dom_ticks_sel(VARIANT, DOM_TICKS_A, DOM_TICKS_B, DOM_TICKS_C);

  lin_mode_e mode;
  logic      pwr_done, en_done, sleep_done;

  lin_tick_timer #(.TICKS(PWRUP_TICKS)) u_pwr_timer (
    .clk_i (clk_i), .rst_ni (rst_ni), .run_i (vs_ok_i), .done_o (pwr_done)
  );

  lin_tick_timer #(.TICKS(NORM_TICKS)) u_en_timer (
    .clk_i (clk_i), .rst_ni (rst_ni),
    .run_i (vs_ok_i && mode == MODE_PRE && en_i), .done_o (en_done)
  );

  lin_tick_timer #(.TICKS(SLEEP_TICKS)) u_sleep_timer (
    .clk_i (clk_i), .rst_ni (rst_ni),
    .run_i (vs_ok_i && mode == MODE_NORM && !en_i), .done_o (sleep_done)
  );

  lin_mode_fsm u_fsm (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .vs_ok_i      (vs_ok_i),
    .en_i         (en_i),
    .bus_wake_i   (bus_wake_i),
    .local_wake_i (local_wake_i),
    .en_done_i    (en_done),
    .sleep_done_i (sleep_done),
    .mode_o       (mode)
  );

  lin_txd_guard #(.VARIANT(VARIANT), .DOM_TICKS(DOM_TICKS)) u_guard (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .vs_ok_i (vs_ok_i),
    .mode_i  (mode),
    .txd_i   (txd_i),
    .dom_o   (lin_dom_o),
    .tmo_o   (txd_tmo_o)
  );

  assign mode_o      = mode;
  assign inh_o       = pwr_done && (mode == MODE_PRE || mode == MODE_NORM);
  assign comm_en_o   = (mode == MODE_NORM);
  assign pullup_en_o = (mode == MODE_NORM);

  assert_inh_needs_supply_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !vs_ok_i |=> !inh_o);
  assert_dom_only_txd_low_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lin_dom_o |-> (!txd_i && pullup_en_o));
endmodule

// File: tb/lin_mode_ctrl_tb_top.sv
module lin_mode_ctrl_tb_top;
  localparam int unsigned PW = 12, NT = 3, ST = 5, DA = 20, DB = 35, DC = 27;

  logic clk = 1'b0, rst_n = 1'b0;
  logic vs = 1'b0, en = 1'b0, txd = 1'b1, bwk = 1'b0, lwk = 1'b0;
  logic [1:0] mode_w [4];
  logic inh_w [4], comm_w [4], pu_w [4], dom_w [4], tmo_w [4];
  int checks = 0, failures = 0;
  bit cmp_on = 0;

  always #2 clk = ~clk;

  lin_mode_ctrl #(.VARIANT(0), .PWRUP_TICKS(PW), .NORM_TICKS(NT), .SLEEP_TICKS(ST),
    .DOM_TICKS_A(DA), .DOM_TICKS_B(DB), .DOM_TICKS_C(DC)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .vs_ok_i(vs), .en_i(en), .txd_i(txd),
    .bus_wake_i(bwk), .local_wake_i(lwk), .mode_o(mode_w[0]), .inh_o(inh_w[0]),
    .comm_en_o(comm_w[0]), .pullup_en_o(pu_w[0]), .lin_dom_o(dom_w[0]), .txd_tmo_o(tmo_w[0]));
  lin_mode_ctrl #(.VARIANT(1), .PWRUP_TICKS(PW), .NORM_TICKS(NT), .SLEEP_TICKS(ST),
    .DOM_TICKS_A(DA), .DOM_TICKS_B(DB), .DOM_TICKS_C(DC)) dut_b_i (
    .clk_i(clk), .rst_ni(rst_n), .vs_ok_i(vs), .en_i(en), .txd_i(txd),
    .bus_wake_i(bwk), .local_wake_i(lwk), .mode_o(mode_w[1]), .inh_o(inh_w[1]),
    .comm_en_o(comm_w[1]), .pullup_en_o(pu_w[1]), .lin_dom_o(dom_w[1]), .txd_tmo_o(tmo_w[1]));
  lin_mode_ctrl #(.VARIANT(2), .PWRUP_TICKS(PW), .NORM_TICKS(NT), .SLEEP_TICKS(ST),
    .DOM_TICKS_A(DA), .DOM_TICKS_B(DB), .DOM_TICKS_C(DC)) dut_c_i (
    .clk_i(clk), .rst_ni(rst_n), .vs_ok_i(vs), .en_i(en), .txd_i(txd),
    .bus_wake_i(bwk), .local_wake_i(lwk), .mode_o(mode_w[2]), .inh_o(inh_w[2]),
    .comm_en_o(comm_w[2]), .pullup_en_o(pu_w[2]), .lin_dom_o(dom_w[2]), .txd_tmo_o(tmo_w[2]));
  lin_mode_ctrl #(.VARIANT(5), .PWRUP_TICKS(PW), .NORM_TICKS(NT), .SLEEP_TICKS(ST),
    .DOM_TICKS_A(DA), .DOM_TICKS_B(DB), .DOM_TICKS_C(DC)) dut_x_i (
    .clk_i(clk), .rst_ni(rst_n), .vs_ok_i(vs), .en_i(en), .txd_i(txd),
    .bus_wake_i(bwk), .local_wake_i(lwk), .mode_o(mode_w[3]), .inh_o(inh_w[3]),
    .comm_en_o(comm_w[3]), .pullup_en_o(pu_w[3]), .lin_dom_o(dom_w[3]), .txd_tmo_o(tmo_w[3]));

  // cycle model of variant 0, built from the requirements
  int m_mode = 0, m_pw = 0, m_en = 0, m_sl = 0, m_dom = 0;
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_mode <= 0; m_pw <= 0; m_en <= 0; m_sl <= 0; m_dom <= 0;
    end else if (!vs) begin
      m_mode <= 0; m_pw <= 0; m_en <= 0; m_sl <= 0; m_dom <= 0;
    end else begin
      m_pw  <= (m_pw < PW) ? m_pw + 1 : m_pw;
      m_en  <= (m_mode == 1 && en)  ? ((m_en < NT) ? m_en + 1 : m_en) : 0;
      m_sl  <= (m_mode == 2 && !en) ? ((m_sl < ST) ? m_sl + 1 : m_sl) : 0;
      m_dom <= (m_mode == 2 && !txd) ? ((m_dom < DA) ? m_dom + 1 : m_dom) : 0;
      case (m_mode)
        0: m_mode <= 1;
        1: if (en && m_en == NT) m_mode <= 2;
        2: if (!en && m_sl == ST) m_mode <= 3;
        3: if (bwk || lwk) m_mode <= 1;
        default: m_mode <= 0;
      endcase
    end
  end

  function automatic int exp_inh(int md, int pw);
    return (pw == PW && (md == 1 || md == 2)) ? 1 : 0;
  endfunction
  function automatic int exp_dom(int md, int dc, logic t);
    return (md == 2 && !t && dc < DA) ? 1 : 0;
  endfunction

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk_mode_all(input string tag, input int exp);
    for (int k = 0; k < 4; k++) chk(tag, mode_w[k], exp);
  endtask

  initial begin
    void'($urandom(32'd4242));
    step(3);
    chk_mode_all("R1 mode in reset", 0);
    chk("R1 inh", inh_w[0], 0); chk("R1 comm", comm_w[0], 0); chk("R1 pullup", pu_w[0], 0);
    chk("R1 dom", dom_w[0], 0); chk("R1 tmo", tmo_w[0], 0);
    rst_n = 1'b1;
    step(2);
    chk("R2 stays off without supply", mode_w[0], 0);

    vs = 1'b1; step(1);
    chk_mode_all("R3 off to pre", 1);
    chk("R3 inh before delay", inh_w[0], 0);
    step(PW - 2);
    chk("R3 inh one tick early", inh_w[0], 0);
    step(1);
    chk("R3 inh after delay", inh_w[0], 1);
    chk("R7 comm off in pre", comm_w[0], 0);
    chk("R7 pullup off in pre", pu_w[0], 0);

    en = 1'b1; step(NT);
    en = 1'b0; step(1);
    chk("R4 short en restarts", mode_w[0], 1);
    en = 1'b1; step(NT);
    chk("R4 not yet normal", mode_w[0], 1);
    step(1);
    chk_mode_all("R4 pre to normal", 2);
    chk("R7 comm on in normal", comm_w[0], 1);
    chk("R7 pullup on in normal", pu_w[0], 1);
    chk("R7 inh on in normal", inh_w[0], 1);
    chk("R8 recessive with txd high", dom_w[0], 0);
    step(1);
    txd = 1'b0; #1;
    for (int k = 0; k < 4; k++) chk("R8 dominant on txd low", dom_w[k], 1);

    step(DA - 1);
    chk("R9 variant 0 before time-out", dom_w[0], 1);
    step(1);
    chk("R9 variant 0 timed out dom", dom_w[0], 0);
    chk("R9 variant 0 tmo flag", tmo_w[0], 1);
    chk("R11 fallback timed out", dom_w[3], 0);
    chk("R11 fallback tmo", tmo_w[3], 1);
    chk("R9 variant 2 still driving", dom_w[2], 1);
    step(DC - DA - 1);
    chk("R9 variant 2 before time-out", dom_w[2], 1);
    step(1);
    chk("R9 variant 2 timed out", dom_w[2], 0);
    chk("R9 variant 1 still driving", dom_w[1], 1);
    step(DB - DC - 1);
    chk("R9 variant 1 before time-out", dom_w[1], 1);
    step(1);
    chk("R9 variant 1 timed out", dom_w[1], 0);
    chk("R9 variant 1 tmo", tmo_w[1], 1);
    txd = 1'b1; step(1);
    for (int k = 0; k < 4; k++) chk("R9 tmo released by txd high", tmo_w[k], 0);
    txd = 1'b0; #1;
    for (int k = 0; k < 4; k++) chk("R9 driver re-enabled", dom_w[k], 1);
    txd = 1'b1;

    en = 1'b0; step(ST);
    chk("R5 not yet sleep", mode_w[0], 2);
    step(1);
    chk_mode_all("R5 normal to sleep", 3);
    chk("R7 inh off in sleep", inh_w[0], 0);
    chk("R7 comm off in sleep", comm_w[0], 0);
    chk("R7 pullup off in sleep", pu_w[0], 0);
    txd = 1'b0; #1;
    chk("R8 no dominant in sleep", dom_w[0], 0);
    txd = 1'b1;
    step(3);
    chk("R6 sleep holds without wake", mode_w[0], 3);

    bwk = 1'b1; step(1); bwk = 1'b0;
    chk_mode_all("R6 bus wake to pre", 1);
    chk("R7 inh back on in pre", inh_w[0], 1);
    lwk = 1'b1; step(2); lwk = 1'b0;
    chk("R6 wake ignored in pre", mode_w[0], 1);

    txd = 1'b0; en = 1'b1; step(NT + 1);
    chk_mode_all("R4 normal with txd low", 2);
    #1;
    chk("R10 variant 0 drives at entry", dom_w[0], 1);
    chk("R11 fallback drives at entry", dom_w[3], 1);
    chk("R10 variant 1 recessive at entry", dom_w[1], 0);
    chk("R10 variant 2 recessive at entry", dom_w[2], 0);
    step(1);
    chk("R10 variant 1 still recessive", dom_w[1], 0);
    txd = 1'b1; step(1);
    bwk = 1'b1; step(1); bwk = 1'b0;
    chk("R6 wake ignored in normal", mode_w[0], 2);
    txd = 1'b0; #1;
    chk("R10 variant 1 armed after txd high", dom_w[1], 1);
    chk("R10 variant 2 armed after txd high", dom_w[2], 1);
    txd = 1'b1;

    en = 1'b0; step(ST + 1);
    chk("R5 sleep again", mode_w[0], 3);
    lwk = 1'b1; step(1); lwk = 1'b0;
    chk_mode_all("R6 local wake to pre", 1);

    en = 1'b1; step(NT + 1);
    chk("R4 normal before supply drop", mode_w[0], 2);
    vs = 1'b0; txd = 1'b0; step(1);
    chk_mode_all("R2 supply drop forces off", 0);
    chk("R2 inh off", inh_w[0], 0);
    chk("R2 dom off", dom_w[0], 0);
    chk("R2 comm off", comm_w[0], 0);
    vs = 1'b1; txd = 1'b1; step(PW - 1);
    chk("R2 power-up count restarted", inh_w[0], 0);
    step(1);
    chk("R3 inh after restart", inh_w[0], 1);

    cmp_on = 1'b1;
    for (int i = 0; i < 6000; i++) begin
      int r;
      @(negedge clk);
      chk("R2 rand mode", mode_w[0], m_mode);
      chk("R7 rand inh", inh_w[0], exp_inh(m_mode, m_pw));
      chk("R7 rand comm", comm_w[0], (m_mode == 2) ? 1 : 0);
      chk("R8 rand dom", dom_w[0], exp_dom(m_mode, m_dom, txd));
      chk("R11 rand fallback", {30'd0, mode_w[3]} + 4 * int'(dom_w[3]),
          m_mode + 4 * exp_dom(m_mode, m_dom, txd));
      r = $urandom;
      vs  = (r % 90) != 0;
      if (((r >> 8) % 14) == 0) en = ~en;
      if (((r >> 12) % 25) == 0) txd = ~txd;
      bwk = ((r >> 17) % 40) == 0;
      lwk = ((r >> 23) % 45) == 0;
      #1;
      chk("R8 rand dom after drive", dom_w[0], exp_dom(m_mode, m_dom, txd));
    end
    cmp_on = 1'b0;

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", checks, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule